// File: doc/BRIEF.md
# ADC Result Threshold Comparator

This block sits beside a converter's result path and watches the stream of finished conversions. Each result arrives as a one-cycle valid strobe together with the number of the sample slot that produced it (0 to 18) and a 12-bit value. Four independent comparators each follow one chosen slot. Each checks every result of that slot against its own threshold, using either a "below" or an "at or above" test. A comparator raises a sticky flag once its test has passed on a programmed number of consecutive results of its slot.

Comparators can be paired for band detection. When the pair bit is set on comparator 0, flag 0 sets only when the result satisfies both comparator 0's test and comparator 1's test. Comparators 2 and 3 pair the same way. Flags stay set until a write-one-to-clear strobe removes them. A single interrupt line is raised while any flag whose interrupt enable is set is high. Software configuration arrives on plain input vectors, and each comparator occupies one field of each vector.

Top module: `adc_threshold_monitor`

## Requirements
- R1: Condition bit 0 selects "result < threshold" and bit 1 selects "result >= threshold". A result equal to the threshold therefore fails the first test and passes the second.
- R2: The 4-bit count field holds N-1. The flag sets in the cycle after the N-th consecutive passing result of the selected slot, and not earlier. A count field of 0 sets the flag on the first passing result.
- R3: A failing result of the selected slot clears that comparator's run of consecutive passes, so N new passes are needed again.
- R4: Cycles with the valid strobe low, and results from any other slot, leave a comparator's run unchanged.
- R5: Pair bit 0 makes comparator 0's pass require comparator 1's test as well, and pair bit 2 does the same for comparator 2 with comparator 3. Both tests use comparator 0's or 2's slot and result, and the partner must be enabled. Pair bits 1 and 3 have no effect.
- R6: Flags are sticky. flag_clr bit i clears flag i on the next edge. If a new set and a clear of the same flag occur in one cycle, the set wins.
- R7: irq is high exactly while some flag i is set and irq_en bit i is 1.
- R8: A comparator with its enable at 0 never sets its flag, and its run restarts from zero when it is enabled again.
- R9: After reset all flags are 0, irq is 0 and every run is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | One-cycle strobe: a conversion result is present |
| res_slot | input | 5 | Sample slot that produced the result |
| res_data | input | 12 | Conversion result value |
| cfg_en | input | 4 | Per-comparator enable |
| cfg_slot | input | 20 | Slot watched by each comparator, 5 bits each, comparator i at [5i+4:5i] |
| cfg_cond | input | 4 | Per-comparator condition (0 below, 1 at or above) |
| cfg_thresh | input | 48 | Thresholds, 12 bits each, comparator i at [12i+11:12i] |
| cfg_mcnt | input | 16 | Required consecutive passes minus one, 4 bits each, comparator i at [4i+3:4i] |
| cfg_win | input | 4 | Pair bits; only bits 0 and 2 act |
| cfg_irq_en | input | 4 | Per-flag interrupt enable |
| flag_clr | input | 4 | Write-one-to-clear strobe for the flags |
| flags | output | 4 | Sticky comparator flags |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to bring about is a run that a foreign-slot result or an idle cycle interrupts. If such an interruption wrongly restarted the run, the design would show it only through a missing flag several results later. The stimulus builds partial runs, inserts other-slot and strobe-low cycles, and then completes the run, so that a flag appears on exactly the expected result. Pair mode is reached by choosing a value that one test of the pair accepts and the other rejects, and then a value inside the band. A further case sets and clears the same flag in one cycle.

// File: rtl/adc_threshold_monitor.sv
module adc_threshold_monitor #(
  parameter int SLOT_W = 5,
  parameter int DATA_W = 12,
  parameter int MCNT_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  res_valid,
  input  logic [SLOT_W-1:0]     res_slot,
  input  logic [DATA_W-1:0]     res_data,
  input  logic [3:0]            cfg_en,
  input  logic [4*SLOT_W-1:0]   cfg_slot,
  input  logic [3:0]            cfg_cond,
  input  logic [4*DATA_W-1:0]   cfg_thresh,
  input  logic [4*MCNT_W-1:0]   cfg_mcnt,
  input  logic [3:0]            cfg_win,
  input  logic [3:0]            cfg_irq_en,
  input  logic [3:0]            flag_clr,
  output logic [3:0]            flags,
  output logic                  irq
);
  localparam int NCMP = 4;

  logic [NCMP-1:0]   cond_ok, eff, sel, set_v;
  logic [MCNT_W-1:0] cnt [NCMP];

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    logic [DATA_W-1:0] thr;
    logic [MCNT_W-1:0] need;
    assign thr  = cfg_thresh[g*DATA_W +: DATA_W];
    assign need = cfg_mcnt[g*MCNT_W +: MCNT_W];
    assign cond_ok[g] = cfg_cond[g] ? (res_data >= thr) : (res_data < thr);
    assign sel[g] = res_valid && cfg_en[g] && (res_slot == cfg_slot[g*SLOT_W +: SLOT_W]);

    if (g % 2 == 0) begin : g_lead
      assign eff[g] = cond_ok[g] && (!cfg_win[g] || (cfg_en[g+1] && cond_ok[g+1]));
      // R5
      pair_partner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flags[g]) && $past(cfg_win[g])) |-> $past(cfg_en[g+1]));
    end else begin : g_follow
      assign eff[g] = cond_ok[g];
    end

    assign set_v[g] = sel[g] && eff[g] && (cnt[g] == need);

    always_ff @(posedge clk) begin
      if (!rst_n || !cfg_en[g])
        cnt[g] <= '0;
      else if (sel[g]) begin
        if (!eff[g])
          cnt[g] <= '0;
        else if (cnt[g] != need)
          cnt[g] <= cnt[g] + 1'b1;
      end
    end

    // R2
    rise_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[g]) |-> $past(res_valid && (res_slot == cfg_slot[g*SLOT_W +: SLOT_W])));
    // R6
    clr_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(flag_clr[g] && !res_valid) |-> !flags[g]);
    // R8
    off_count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en[g] |=> (cnt[g] == '0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      flags <= '0;
    else
      flags <= (flags & ~flag_clr) | set_v;
  end

  assign irq = |(flags & cfg_irq_en);
endmodule

// File: tb/tb_adc_threshold_monitor.sv
module tb_adc_threshold_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic res_valid = 1'b0;
  logic [4:0] res_slot = '0;
  logic [11:0] res_data = '0;
  logic [3:0] cfg_en = '0, cfg_cond = '0, cfg_win = '0, cfg_irq_en = '0, flag_clr = '0;
  logic [19:0] cfg_slot = '0;
  logic [47:0] cfg_thresh = '0;
  logic [15:0] cfg_mcnt = '0;
  logic [3:0] flags;
  logic irq;

  always #10 clk = ~clk;

  adc_threshold_monitor dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_slot(res_slot),
    .res_data(res_data), .cfg_en(cfg_en), .cfg_slot(cfg_slot), .cfg_cond(cfg_cond),
    .cfg_thresh(cfg_thresh), .cfg_mcnt(cfg_mcnt), .cfg_win(cfg_win),
    .cfg_irq_en(cfg_irq_en), .flag_clr(flag_clr), .flags(flags), .irq(irq));

  logic       s_en [4], s_cond [4], s_win [4], s_ie [4];
  logic [4:0] s_slot [4];
  logic [11:0] s_th [4];
  logic [3:0] s_mc [4];
  logic [3:0] m_cnt [4];
  logic [3:0] m_flags;

  typedef struct packed { logic [3:0] f; logic i; } exp_t;
  exp_t  exp_q [$];
  string tag_q [$];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic put(input logic v, input logic [4:0] sl, input logic [11:0] d,
                     input logic [3:0] clr, input string tag);
    logic ok [4];
    logic [3:0] setv;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      cfg_en[i] = s_en[i]; cfg_cond[i] = s_cond[i]; cfg_win[i] = s_win[i];
      cfg_irq_en[i] = s_ie[i]; cfg_slot[i*5 +: 5] = s_slot[i];
      cfg_thresh[i*12 +: 12] = s_th[i]; cfg_mcnt[i*4 +: 4] = s_mc[i];
    end
    res_valid = v; res_slot = sl; res_data = d; flag_clr = clr;
    for (int i = 0; i < 4; i++) ok[i] = s_cond[i] ? (d >= s_th[i]) : (d < s_th[i]);
    setv = '0;
    for (int i = 0; i < 4; i++) begin
      logic pass;
      pass = ok[i];
      if ((i == 0 || i == 2) && s_win[i]) pass = pass && s_en[i+1] && ok[i+1];
      if (!s_en[i]) m_cnt[i] = 0;
      else if (v && sl == s_slot[i]) begin
        if (!pass) m_cnt[i] = 0;
        else if (m_cnt[i] == s_mc[i]) setv[i] = 1'b1;
        else m_cnt[i] = m_cnt[i] + 1;
      end
    end
    m_flags = (m_flags & ~clr) | setv;
    exp_q.push_back('{f: m_flags,
      i: |(m_flags & {s_ie[3], s_ie[2], s_ie[1], s_ie[0]})});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    put(1'b0, 5'd0, 12'd0, 4'b0, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (flags !== e.f || irq !== e.i) begin
          errors++;
          $display("FAIL %s: flags=%b irq=%b expected flags=%b irq=%b",
                   t, flags, irq, e.f, e.i);
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      s_en[i] = 0; s_cond[i] = 0; s_win[i] = 0; s_ie[i] = 0;
      s_slot[i] = 0; s_th[i] = 0; s_mc[i] = 0; m_cnt[i] = 0;
    end
    m_flags = '0;
    repeat (3) @(posedge clk);
    #5;
    checks++;
    if (flags !== 4'b0 || irq !== 1'b0) begin
      errors++;
      $display("FAIL R9: flags=%b irq=%b expected flags=0000 irq=0", flags, irq);
    end
    @(negedge clk);
    rst_n = 1'b1;
    idle("R9 after reset");

    // R2 / R1: ten results at or above 0x800 on slot 5, count field 9
    s_en[0] = 1; s_slot[0] = 5; s_cond[0] = 1; s_th[0] = 12'h800; s_mc[0] = 9; s_ie[0] = 1;
    for (int k = 0; k < 10; k++) put(1, 5'd5, 12'h800 + 12'(k), 4'b0, "R2 ten consecutive passes");
    idle("R7 irq follows flag");
    put(0, 5'd0, 12'd0, 4'b0001, "R6 clear flag 0");
    s_en[0] = 0;
    put(1, 5'd5, 12'hFFF, 4'b0, "R8 disabled comparator");
    s_en[0] = 1; s_mc[0] = 1;
    put(1, 5'd5, 12'hFFF, 4'b0, "R8 run restarts after enable");
    put(1, 5'd5, 12'hFFF, 4'b0, "R8 second pass sets");
    put(0, 5'd0, 12'd0, 4'b0001, "R6 clear");
    s_en[0] = 0;

    // R3: run broken by a failing result
    s_en[1] = 1; s_slot[1] = 3; s_cond[1] = 0; s_th[1] = 12'h100; s_mc[1] = 2; s_ie[1] = 0;
    put(1, 5'd3, 12'h010, 4'b0, "R3 pass 1");
    put(1, 5'd3, 12'h020, 4'b0, "R3 pass 2");
    put(1, 5'd3, 12'h200, 4'b0, "R3 failing result");
    put(1, 5'd3, 12'h030, 4'b0, "R3 pass 1 again");
    put(1, 5'd3, 12'h040, 4'b0, "R3 pass 2 again");
    put(1, 5'd3, 12'h050, 4'b0, "R3 third pass sets");
    put(0, 5'd0, 12'd0, 4'b0010, "R6 clear 1");
    s_en[1] = 0;

    // R1 threshold boundaries
    s_en[2] = 1; s_slot[2] = 7; s_cond[2] = 0; s_th[2] = 12'h300; s_mc[2] = 0; s_ie[2] = 1;
    s_en[3] = 1; s_slot[3] = 7; s_cond[3] = 1; s_th[3] = 12'hFFF; s_mc[3] = 0; s_ie[3] = 1;
    put(1, 5'd7, 12'h300, 4'b0, "R1 equal fails below-test");
    put(1, 5'd7, 12'h2FF, 4'b0, "R1 one under passes below-test");
    put(1, 5'd7, 12'hFFE, 4'b0, "R1 under 0xFFF fails at-or-above");
    put(1, 5'd7, 12'hFFF, 4'b0, "R1 equal passes at-or-above");
    // R6 set wins over clear in the same cycle
    put(1, 5'd7, 12'hFFF, 4'b1000, "R6 set beats clear");
    put(0, 5'd0, 12'd0, 4'b1100, "R6 clear 2 and 3");
    s_en[3] = 0;

    // R4: other slots and idle cycles keep the run
    s_slot[2] = 18; s_cond[2] = 1; s_th[2] = 12'h100; s_mc[2] = 1;
    put(1, 5'd18, 12'h200, 4'b0, "R4 pass 1");
    put(1, 5'd4, 12'h000, 4'b0, "R4 other slot failing value");
    put(0, 5'd18, 12'h000, 4'b0, "R4 strobe low");
    put(1, 5'd18, 12'h300, 4'b0, "R4 pass 2 sets");
    put(0, 5'd0, 12'd0, 4'b0100, "R6 clear 2");
    s_en[2] = 0;

    // R5 pair mode on comparators 0/1
    s_en[0] = 1; s_slot[0] = 2; s_cond[0] = 1; s_th[0] = 12'h400; s_mc[0] = 0; s_win[0] = 1; s_ie[0] = 1;
    s_en[1] = 1; s_slot[1] = 9; s_cond[1] = 0; s_th[1] = 12'h600; s_mc[1] = 0; s_ie[1] = 1;
    put(1, 5'd2, 12'h700, 4'b0, "R5 outside band");
    put(1, 5'd2, 12'h500, 4'b0, "R5 inside band");
    put(0, 5'd0, 12'd0, 4'b0001, "R6 clear 0");
    s_win[1] = 1;
    put(1, 5'd9, 12'h100, 4'b0, "R5 pair bit 1 ignored");
    s_en[1] = 0;
    put(1, 5'd2, 12'h500, 4'b0, "R5 partner disabled blocks");
    s_ie[1] = 0;
    idle("R7 irq enable gating");
    s_ie[0] = 1; s_en[1] = 1; s_win[0] = 0;
    put(1, 5'd2, 12'h700, 4'b0, "R5 pair off passes alone");
    s_ie[0] = 0;
    idle("R7 irq off with flags set");
    put(0, 5'd0, 12'd0, 4'b1111, "R6 clear all");

    // R5 pair mode on comparators 2/3
    s_en[0] = 0; s_en[1] = 0; s_win[1] = 0;
    s_en[2] = 1; s_slot[2] = 11; s_cond[2] = 0; s_th[2] = 12'h200; s_mc[2] = 0; s_win[2] = 1; s_ie[2] = 1;
    s_en[3] = 1; s_slot[3] = 1; s_cond[3] = 1; s_th[3] = 12'h080; s_mc[3] = 0;
    put(1, 5'd11, 12'h040, 4'b0, "R5 below lower edge");
    put(1, 5'd11, 12'h100, 4'b0, "R5 band 2/3");
    idle("R5 settle");

    repeat (3) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end
endmodule